// File: doc/BRIEF.md
# Primitive dispatch command processor

This block takes one stream of tagged graphics commands and hands them out to a set of downstream geometry workers. Each worker has its own valid/ready output. A command is one 2-bit kind plus a 32-bit payload. The data and kind lines are shared by all workers, and each worker has its own valid bit. A command that works on one primitive goes to a single worker, picked in fixed rotation, and the choice does not depend on how busy the workers are. A global state command goes to every worker. Nothing else passes until all workers have taken that state command.

A connected strip longer than the group limit is cut into short groups, and each group goes whole to one worker. At a cut, the block closes the current group with an end word. It then opens a new group on the next worker, using the original begin payload. It replays the last two vertices so that no triangle is lost, and then passes the incoming vertex. Attribute data travels in the vertex words, so it always reaches the same worker as its primitive.

Top module: `cmd_dispatch`

## Requirements
- R1: While reset is held and after it is released, every worker valid is low and cmd_ready is high. The first primitive after reset goes to worker 0.
- R2: The command kind is encoded as 00 = vertex, 01 = begin strip, 10 = end strip, 11 = global state. A vertex received outside a strip is a standalone primitive. It goes to one worker, and the next primitive goes to the next worker in the order 0, 1, …, NW-1, 0. An accepted command shows up on the outputs in the cycle after it is accepted.
- R3: A begin word, the vertices that follow it and its end word all go to the same worker. The rotation moves on by one worker after the end word. An end word received outside a strip is sent like a standalone primitive.
- R4: A strip vertex can arrive when the open group already holds MAXV vertices. The block then sends the current worker an end word with payload 0. It then sends the next worker, in this order: a begin word carrying the strip's original begin payload, the two most recent vertices (older one first), and then the incoming vertex.
- R5: A global state word goes to every worker and leaves the rotation unchanged. Broadcasts inside a strip do not disturb the strip.
- R6: While any worker has not yet taken a broadcast, cmd_ready stays low. No word for a single worker is delivered until all workers have taken the broadcast.
- R7: An output word stays stable while its valid is high and ready is low. Each word reaches each of its targets exactly once.
- R8: A word for a single worker raises exactly one worker valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cmd_valid | input | 1 | Input command valid |
| cmd_ready | output | 1 | Input command accepted when high with valid |
| cmd_type | input | 2 | Command kind |
| cmd_data | input | DW | Command payload |
| w_valid | output | NW | Per-worker output valid |
| w_ready | input | NW | Per-worker ready |
| w_type | output | 2 | Output word kind, shared by all workers |
| w_data | output | DW | Output payload, shared by all workers |

## Verification
Runs of standalone vertices show that the rotation order and the reset start point are right. Strips of length MAXV and just under it show that no cut happens too early. Strips several groups long show that the closing end word, the replayed vertices, their order and the move to the next worker are all right. Broadcasts are placed both between primitives and inside strips, with random per-worker ready stalls. These runs separate correct all-accept synchronization from a broadcast that lets later words overtake it, and they show that broadcasts leave the strip counters and the rotation untouched.

// File: rtl/cmd_disp_pkg.sv
package cmd_disp_pkg;
  typedef enum logic [1:0] {
    CK_VTX   = 2'b00,
    CK_BEGIN = 2'b01,
    CK_END   = 2'b10,
    CK_STATE = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BEG  = 2'd1,
    SQ_R0   = 2'd2,
    SQ_R1   = 2'd3
  } seq_e;
endpackage

// File: rtl/cmd_rr_ptr.sv
module cmd_rr_ptr #(
  parameter int NW = 4,
  localparam int PW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [NW-1:0] cur_oh
);
  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == PW'(NW - 1)) ptr_d = '0;
      else                      ptr_d = ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < NW; i++) begin : g_dec
    assign cur_oh[i] = (ptr_q == PW'(i));
  end
endmodule

// File: rtl/cmd_strip_state.sv
module cmd_strip_state #(
  parameter int MAXV = 6,
  parameter int DW   = 32,
  localparam int CW  = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          push,
  input  logic          finish,
  input  logic          replayed,
  input  logic [DW-1:0] in_data,
  output logic          in_strip,
  output logic          full,
  output logic [DW-1:0] beg_data,
  output logic [DW-1:0] hist_old,
  output logic [DW-1:0] hist_new
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en, hist_en;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    cnt_en = start | push | finish | replayed;
    if (start) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (finish) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (replayed) begin
      cnt_d = CW'(2);
    end else if (push) begin
      cnt_d = cnt_q + CW'(1);
    end
    hist_en = push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) beg_data <= in_data;
    if (hist_en) begin
      hist_old <= hist_new;
      hist_new <= in_data;
    end
  end

  assign in_strip = act_q;
  assign full     = (cnt_q >= CW'(MAXV));
endmodule

// File: rtl/cmd_out_slot.sv
module cmd_out_slot #(
  parameter int NW = 4,
  parameter int WW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] load_mask,
  input  logic [WW-1:0] load_word,
  input  logic [NW-1:0] w_ready,
  output logic [NW-1:0] w_valid,
  output logic [WW-1:0] word,
  output logic          free
);
  logic [NW-1:0] mask_q, mask_d, left;

  always_comb begin
    left   = mask_q & ~w_ready;
    free   = (left == '0);
    mask_d = load ? load_mask : left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (load) word <= load_word;
  end

  assign w_valid = mask_q;
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_disp_pkg::*;
#(
  parameter int NW   = 4,
  parameter int MAXV = 6,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_type,
  input  logic [DW-1:0] cmd_data,
  output logic [NW-1:0] w_valid,
  input  logic [NW-1:0] w_ready,
  output logic [1:0]    w_type,
  output logic [DW-1:0] w_data
);
  localparam int WW = DW + 2;

  seq_e          seq_q, seq_d;
  logic          free, load, adv;
  logic [NW-1:0] cur_oh, load_mask;
  logic [WW-1:0] load_word, slot_word;
  logic          st_start, st_push, st_finish, st_replay;
  logic          in_strip, full;
  logic [DW-1:0] beg_data, hist_old, hist_new;
  cmd_kind_e     kind;
  logic          split_now;

  assign kind      = cmd_kind_e'(cmd_type);
  assign split_now = cmd_valid && (kind == CK_VTX) && in_strip && full;

  cmd_rr_ptr #(.NW(NW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cur_oh(cur_oh)
  );

  cmd_strip_state #(.MAXV(MAXV), .DW(DW)) u_strip (
    .clk(clk), .rst_n(rst_n), .start(st_start), .push(st_push),
    .finish(st_finish), .replayed(st_replay), .in_data(cmd_data),
    .in_strip(in_strip), .full(full), .beg_data(beg_data),
    .hist_old(hist_old), .hist_new(hist_new)
  );

  cmd_out_slot #(.NW(NW), .WW(WW)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(load), .load_mask(load_mask),
    .load_word(load_word), .w_ready(w_ready), .w_valid(w_valid),
    .word(slot_word), .free(free)
  );

  always_comb begin
    seq_d     = seq_q;
    load      = 1'b0;
    load_mask = cur_oh;
    load_word = {cmd_type, cmd_data};
    adv       = 1'b0;
    cmd_ready = 1'b0;
    st_start  = 1'b0;
    st_push   = 1'b0;
    st_finish = 1'b0;
    st_replay = 1'b0;
    unique case (seq_q)
      SQ_IDLE: begin
        if (free) begin
          if (split_now) begin
            load      = 1'b1;
            load_word = {CK_END, {DW{1'b0}}};
            adv       = 1'b1;
            seq_d     = SQ_BEG;
          end else begin
            cmd_ready = 1'b1;
            if (cmd_valid) begin
              load = 1'b1;
              unique case (kind)
                CK_STATE: load_mask = '1;
                CK_BEGIN: st_start  = 1'b1;
                CK_END: begin
                  adv       = 1'b1;
                  st_finish = 1'b1;
                end
                CK_VTX: begin
                  if (in_strip) st_push = 1'b1;
                  else          adv     = 1'b1;
                end
                default: ;
              endcase
            end
          end
        end
      end
      SQ_BEG: begin
        if (free) begin
          load      = 1'b1;
          load_word = {CK_BEGIN, beg_data};
          seq_d     = SQ_R0;
        end
      end
      SQ_R0: begin
        if (free) begin
          load      = 1'b1;
          load_word = {CK_VTX, hist_old};
          seq_d     = SQ_R1;
        end
      end
      SQ_R1: begin
        if (free) begin
          load      = 1'b1;
          load_word = {CK_VTX, hist_new};
          st_replay = 1'b1;
          seq_d     = SQ_IDLE;
        end
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= SQ_IDLE;
    else        seq_q <= seq_d;
  end

  assign w_type = slot_word[WW-1:DW];
  assign w_data = slot_word[DW-1:0];
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk #(
  parameter int NW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_type,
  input logic [NW-1:0] w_valid,
  input logic [NW-1:0] w_ready,
  input logic [1:0]    w_type,
  input logic [DW-1:0] w_data
);
  // R2: an accepted command appears on the outputs in the next cycle
  a_r2_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (w_valid != '0));

  // R5: an accepted broadcast raises every worker valid
  a_r5_bcast_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_type == 2'b11) |=> (w_valid == '1 && w_type == 2'b11));

  // R6: input stalls while some worker has not taken the broadcast
  a_r6_bcast_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (w_type == 2'b11 && (w_valid & ~w_ready) != '0) |-> !cmd_ready);

  // R8: a single-worker word has exactly one valid
  a_r8_unicast_single: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid != '0 && w_type != 2'b11) |-> ($countones(w_valid) == 1));

  // R7: words hold while stalled
  for (genvar i = 0; i < NW; i++) begin : g_hold
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid[i] && !w_ready[i]) |=> (w_valid[i] && $stable(w_data) && $stable(w_type)));
  end
endmodule

bind cmd_dispatch cmd_dispatch_chk #(.NW(NW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_type(cmd_type), .w_valid(w_valid), .w_ready(w_ready),
  .w_type(w_type), .w_data(w_data)
);

// File: tb/cmd_dispatch_test.sv
module cmd_dispatch_test;
  localparam int NW = 4;
  localparam int MAXV = 6;
  localparam int DEPTH = 4096;
  localparam int SMAX = 1200;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic cmd_ready;
  logic [1:0] cmd_type;
  logic [31:0] cmd_data;
  logic [NW-1:0] w_valid;
  logic [NW-1:0] w_ready;
  logic [1:0] w_type;
  logic [31:0] w_data;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cmd_dispatch #(.NW(NW), .MAXV(MAXV), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_data(cmd_data), .w_valid(w_valid),
    .w_ready(w_ready), .w_type(w_type), .w_data(w_data)
  );

  // stimulus stream and expected per-worker queues
  logic [1:0]  s_k [SMAX];
  logic [31:0] s_d [SMAX];
  int          s_n = 0;
  logic [33:0] exp_w [NW][DEPTH];
  string       exp_tag [NW][DEPTH];
  int          exp_n [NW];
  int          obs_n [NW];
  int          bc_cnt [NW];

  // reference model state
  int          m_ptr = 0;
  bit          m_strip = 0;
  int          m_cnt = 0;
  logic [31:0] m_beg, m_h0, m_h1;

  task automatic put(int w, logic [1:0] k, logic [31:0] d, string tag);
    exp_w[w][exp_n[w]] = {k, d};
    exp_tag[w][exp_n[w]] = tag;
    exp_n[w]++;
  endtask

  function automatic int nxt(int p);
    return (p == NW - 1) ? 0 : p + 1;
  endfunction

  task automatic emit(logic [1:0] k, logic [31:0] d);
    s_k[s_n] = k; s_d[s_n] = d; s_n++;
    case (k)
      2'b11: for (int w = 0; w < NW; w++) put(w, k, d, "R5");
      2'b01: begin
        put(m_ptr, k, d, "R3");
        m_strip = 1; m_cnt = 0; m_beg = d;
      end
      2'b10: begin
        put(m_ptr, k, d, "R3");
        m_ptr = nxt(m_ptr); m_strip = 0; m_cnt = 0;
      end
      default: begin
        if (!m_strip) begin
          put(m_ptr, k, d, "R2");
          m_ptr = nxt(m_ptr);
        end else begin
          if (m_cnt >= MAXV) begin
            put(m_ptr, 2'b10, 32'd0, "R4");
            m_ptr = nxt(m_ptr);
            put(m_ptr, 2'b01, m_beg, "R4");
            put(m_ptr, 2'b00, m_h0, "R4");
            put(m_ptr, 2'b00, m_h1, "R4");
            put(m_ptr, k, d, "R4");
            m_cnt = 3;
          end else begin
            put(m_ptr, k, d, "R3");
            m_cnt++;
          end
          m_h0 = m_h1; m_h1 = d;
        end
      end
    endcase
  endtask

  task automatic strip(int len, bit with_bc);
    emit(2'b01, $urandom);
    for (int v = 0; v < len; v++) begin
      emit(2'b00, $urandom);
      if (with_bc && ($urandom % 5 == 0)) emit(2'b11, $urandom);
    end
    emit(2'b10, $urandom);
  endtask

  // output monitor: randomize ready, then check handshakes before the edge
  bit stall_on = 0;
  always @(negedge clk) begin
    for (int i = 0; i < NW; i++) w_ready[i] = stall_on ? (($urandom % 4) != 0) : 1'b1;
    #1;
    if (rst_n === 1'b1) begin
      for (int i = 0; i < NW; i++)
        if (w_valid[i] && w_ready[i] && w_type == 2'b11) bc_cnt[i]++;
      for (int i = 0; i < NW; i++) begin
        if (w_valid[i] && w_ready[i]) begin
          tests++;
          if (obs_n[i] >= exp_n[i]) begin
            fails++;
            $display("FAIL R7 worker %0d extra word act=%h exp=none", i, {w_type, w_data});
          end else begin
            if ({w_type, w_data} !== exp_w[i][obs_n[i]]) begin
              fails++;
              $display("FAIL %s worker %0d word %0d act=%h exp=%h", exp_tag[i][obs_n[i]],
                       i, obs_n[i], {w_type, w_data}, exp_w[i][obs_n[i]]);
            end
            obs_n[i]++;
          end
          if (w_type != 2'b11) begin
            tests++;
            if ($countones(w_valid) != 1) begin
              fails++;
              $display("FAIL R8 unicast valid act=%b exp=one bit", w_valid);
            end
            for (int j = 0; j < NW; j++) if (bc_cnt[j] != bc_cnt[i]) begin
              fails++;
              $display("FAIL R6 worker %0d bcasts act=%0d exp=%0d", j, bc_cnt[j], bc_cnt[i]);
            end
          end
        end
      end
    end
  end

  task automatic send(int idx);
    if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk);
    @(negedge clk);
    #2;
    cmd_valid = 1'b1; cmd_type = s_k[idx]; cmd_data = s_d[idx];
    forever begin
      #1;
      if (cmd_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
      #2;
    end
    #1 cmd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < NW; w++) begin exp_n[w] = 0; obs_n[w] = 0; bc_cnt[w] = 0; end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_type = 2'b00; cmd_data = '0;

    // directed part: rotation, exact-length strip, multi-group strips, broadcast
    for (int i = 0; i < 5; i++) emit(2'b00, 32'h100 + i);   // R2
    strip(3, 0);                                              // R3
    emit(2'b11, 32'hCAFE0001);                                // R5
    strip(MAXV, 0);                                           // R4 boundary: no split
    strip(MAXV + 1, 0);                                       // R4 one split
    strip(3 * MAXV, 0);                                       // R4 several splits
    strip(10, 1);                                             // R5 inside strip
    emit(2'b10, 32'h77);                                      // R3 stray end
    emit(2'b11, 32'hCAFE0002);
    emit(2'b11, 32'hCAFE0003);
    strip(0, 0);
    // random part
    while (s_n < SMAX - 40) begin
      int r;
      r = $urandom % 10;
      if (r < 4) emit(2'b00, $urandom);
      else if (r < 7) strip($urandom % 16, 1);
      else if (r < 9) emit(2'b11, $urandom);
      else emit(2'b10, $urandom);
    end

    repeat (4) @(negedge clk);
    #2;
    tests++;  // R1 reset state
    if (w_valid !== '0 || cmd_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 in reset act=%b/%b exp=0000/1", w_valid, cmd_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    tests++;  // R1 after release
    if (w_valid !== '0 || cmd_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 after release act=%b/%b exp=0000/1", w_valid, cmd_ready);
    end

    for (int i = 0; i < s_n; i++) begin
      if (i == 60) stall_on = 1;
      send(i);
    end

    for (int t = 0; t < 3000; t++) begin
      bit done;
      done = 1;
      for (int w = 0; w < NW; w++) if (obs_n[w] != exp_n[w]) done = 0;
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    #3;
    for (int w = 0; w < NW; w++) begin
      tests++;  // R7 each word delivered exactly once
      if (obs_n[w] != exp_n[w]) begin
        fails++;
        $display("FAIL R7 worker %0d words act=%0d exp=%0d", w, obs_n[w], exp_n[w]);
      end
    end
    tests++;  // R7 idle after drain
    if (w_valid !== '0) begin
      fails++;
      $display("FAIL R7 valid after drain act=%b exp=0", w_valid);
    end
    summary();
  end
endmodule